// File: doc/BRIEF.md
# Shadow-Backed Configuration Register Block

This block holds the control registers of a nonvolatile memory module that sits on a 24-bit-address peripheral bus. It decodes the bus address and the function code, acknowledges accesses that fall inside its 32-byte window, and serves reads and writes of three 16-bit registers: a module configuration register, a base address register and a high-voltage control register.

Several fields take their reset values from shadow words kept in a spare row of the memory array. A master reset copies those words into the live registers. Ordinary writes change only the live registers. A shadow-select bit changes what register writes do: they fill a program latch instead of the live register. Setting the high-voltage enable bit then burns the latched value into the matching shadow word. The new value reaches the live register only at the next master reset. Erasing the low array block also erases every shadow word.

The array cells are modelled as a small behavioural store. It starts erased at power-on, and a program operation can only clear bits.

Top module: `cfgsh_regblk`

## Requirements
- R1: The block decodes an access only when address bit 23 equals the live module-map bit (MCR bit 15) and address bits 22:5 equal the device tag parameter (default 18'h2A5C3).
- R2: Only function code 3'b101 is accepted. Any other code gets no acknowledge, and a write made with it leaves every register unchanged.
- R3: `bus_ack` is high in the cycle that a read or write strobe meets a decoded address with an accepted function code, and it is low whenever neither strobe is high.
- R4: Address bits 4:0 select the register. Offset 0x00 is MCR: bit 15 is the module-map bit and bits 7:0 are a configuration field. Offset 0x04 is BAR: all 16 bits. Offset 0x08 is HVC: bits 11:8 are a timing field, bit 1 is shadow select and bit 0 is high-voltage enable. All other bits read as zero and ignore writes.
- R5: While `mrst_n` is low, each shadowed field (MCR bits 15 and 7:0, all of BAR, HVC bits 11:8) loads from its shadow word at each clock edge. All other bits clear to zero.
- R6: A write made while shadow select is 0 never changes any shadow word.
- R7: While shadow select is 1, a write to MCR or BAR, or a write to HVC with bit 0 at 0, loads the program latch with the data and the target register. The live register stays unchanged, except that HVC bits 1:0 still take the written value.
- R8: A write to HVC that sets bit 0 (it was 0, shadow select is 1 and the latch holds data) programs the most recently latched value into that register's shadow word. Programming ANDs the data into the word.
- R9: A programmed shadow value appears in the live register only after the next master reset.
- R10: A one-cycle pulse on `blk_erase` sets every shadow word to all ones.
- R11: With erased shadow words, master reset yields MCR = 0x80FF, BAR = 0xFFFF and HVC = 0x0F00.
- R12: Unimplemented offsets in the window are acknowledged, read as zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| por_n | input | 1 | Power-on reset, active low; sets the behavioural shadow store to the erased state |
| mrst_n | input | 1 | Master reset, active low, synchronous; loads the live registers from the shadow words |
| bus_addr | input | 24 | Byte address |
| bus_fc | input | 3 | Bus function code |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational, zero when the block is not read |
| bus_ack | output | 1 | Address acknowledge, combinational |
| blk_erase | input | 1 | Low-block erase pulse; erases all shadow words |

## Verification
The assertions assume that `bus_rd` and `bus_wr` are never high together, that the bus inputs are held stable across the sampling clock edge, and that `blk_erase` and `mrst_n` change only between edges. The bench drives every input on the falling edge, keeps it through the next rising edge, and never raises both strobes at once. The erase pulse lasts exactly one cycle and is never combined with a program write. This keeps the cycle in which each shadow word changes unambiguous.

// File: rtl/cfgsh_pkg.sv
package cfgsh_pkg;
   localparam int DW      = 16;
   localparam int NREG    = 3;
   localparam int IDX_W   = 2;
   localparam int OFF_W   = 5;
   localparam int IDX_MCR = 0;
   localparam int IDX_BAR = 1;
   localparam int IDX_HVC = 2;
   localparam int MAP_BIT = 15;
   localparam int SHD_BIT = 1;
   localparam int HVE_BIT = 0;

   // per-register offset, writable mask, shadowed mask, mask still live in shadow mode
   localparam logic [NREG-1:0][OFF_W-1:0] REG_OFF  = {5'h08, 5'h04, 5'h00};
   localparam logic [NREG-1:0][DW-1:0]    WR_MASK  = {16'h0F03, 16'hFFFF, 16'h80FF};
   localparam logic [NREG-1:0][DW-1:0]    SHD_MASK = {16'h0F00, 16'hFFFF, 16'h80FF};
   localparam logic [NREG-1:0][DW-1:0]    LIVE_MASK = {16'h0003, 16'h0000, 16'h0000};
endpackage

// File: rtl/cfgsh_decode.sv
module cfgsh_decode
   import cfgsh_pkg::*;
#(
   parameter int          AW      = 24,
   parameter int unsigned DEV_TAG = 'h2A5C3,
   parameter logic [2:0]  FC_OK   = 3'b101
) (
   input  logic [AW-1:0]   addr,
   input  logic [2:0]      fc,
   input  logic            rd,
   input  logic            wr,
   input  logic            map_bit,
   output logic            ack,
   output logic [NREG-1:0] sel
);
   localparam int TAG_W = AW - 1 - OFF_W;

   logic hit;

   // R1, R2: window match on map bit, tag and function code
   assign hit = (addr[AW-1] == map_bit)
             && (addr[AW-2:OFF_W] == TAG_W'(DEV_TAG))
             && (fc == FC_OK);
   // R3
   assign ack = hit && (rd || wr);

   // R4: one-hot register select
   for (genvar i = 0; i < NREG; i++) begin : g_sel
      assign sel[i] = ack && (addr[OFF_W-1:0] == REG_OFF[i]);
   end
endmodule

// File: rtl/cfgsh_shadow_store.sv
module cfgsh_shadow_store
   import cfgsh_pkg::*;
#(
   parameter bit PGM_AND = 1'b1
) (
   input  logic                      clk,
   input  logic                      por_n,
   input  logic                      erase,
   input  logic                      pgm_go,
   input  logic [IDX_W-1:0]          pgm_idx,
   input  logic [DW-1:0]             pgm_data,
   output logic [NREG-1:0][DW-1:0]   words
);
   for (genvar i = 0; i < NREG; i++) begin : g_word
      logic [DW-1:0] nxt;
      // program variant: clear-only cells or plain overwrite
      if (PGM_AND) begin : g_and
         assign nxt = words[i] & pgm_data;
      end else begin : g_ovr
         assign nxt = pgm_data;
      end

      always_ff @(posedge clk or negedge por_n) begin
         if (!por_n)
            words[i] <= '1;
         else if (erase)                                      // R10
            words[i] <= '1;
         else if (pgm_go && (pgm_idx == IDX_W'(i)))           // R8
            words[i] <= nxt;
      end
   end
endmodule

// File: rtl/cfgsh_regs.sv
module cfgsh_regs
   import cfgsh_pkg::*;
(
   input  logic                      clk,
   input  logic                      mrst_n,
   input  logic                      wr,
   input  logic [NREG-1:0]           sel,
   input  logic [DW-1:0]             wdata,
   input  logic [NREG-1:0][DW-1:0]   shd_words,
   output logic [NREG-1:0][DW-1:0]   live,
   output logic                      pgm_go,
   output logic [IDX_W-1:0]          lat_idx,
   output logic [DW-1:0]             lat_data
);
   logic             shd_sel;
   logic             hv_en;
   logic             lat_vld;
   logic             lat_ld;
   logic             sets_hve;
   logic [IDX_W-1:0] sel_idx;

   assign shd_sel  = live[IDX_HVC][SHD_BIT];
   assign hv_en    = live[IDX_HVC][HVE_BIT];
   assign sets_hve = wr && sel[IDX_HVC] && wdata[HVE_BIT];

   always_comb begin
      sel_idx = '0;
      for (int i = 0; i < NREG; i++)
         if (sel[i]) sel_idx = IDX_W'(i);
   end

   // R7: program latch fill; R8: program trigger
   assign lat_ld = wr && shd_sel && (|sel) && !(sel[IDX_HVC] && wdata[HVE_BIT]);
   assign pgm_go = mrst_n && sets_hve && !hv_en && shd_sel && lat_vld;

   always_ff @(posedge clk) begin
      if (!mrst_n) begin
         lat_vld  <= 1'b0;
         lat_idx  <= '0;
         lat_data <= '0;
      end else if (pgm_go) begin
         lat_vld  <= 1'b0;
      end else if (lat_ld) begin
         lat_vld  <= 1'b1;
         lat_idx  <= sel_idx;
         lat_data <= wdata;
      end
   end

   for (genvar i = 0; i < NREG; i++) begin : g_reg
      logic [DW-1:0] wmask;
      assign wmask = shd_sel ? (WR_MASK[i] & LIVE_MASK[i]) : WR_MASK[i];

      always_ff @(posedge clk) begin
         if (!mrst_n)                                          // R5
            live[i] <= shd_words[i] & SHD_MASK[i];
         else if (wr && sel[i])                                // R4, R7
            live[i] <= (live[i] & ~wmask) | (wdata & wmask);
      end
   end
endmodule

// File: rtl/cfgsh_regblk.sv
module cfgsh_regblk
   import cfgsh_pkg::*;
#(
   parameter int          AW      = 24,
   parameter int unsigned DEV_TAG = 'h2A5C3,
   parameter logic [2:0]  FC_OK   = 3'b101,
   parameter bit          PGM_AND = 1'b1
) (
   input  logic          clk,
   input  logic          por_n,
   input  logic          mrst_n,
   input  logic [23:0]   bus_addr,
   input  logic [2:0]    bus_fc,
   input  logic          bus_rd,
   input  logic          bus_wr,
   input  logic [15:0]   bus_wdata,
   output logic [15:0]   bus_rdata,
   output logic          bus_ack,
   input  logic          blk_erase
);
   if (AW != 24) begin : g_bad_aw
      $error("cfgsh_regblk: AW must match the 24-bit port width");
   end
   if (DW != 16) begin : g_bad_dw
      $error("cfgsh_regblk: package DW must be 16");
   end
   if (DEV_TAG >= (1 << (AW - 1 - OFF_W))) begin : g_bad_tag
      $error("cfgsh_regblk: DEV_TAG wider than the tag field");
   end

   logic [NREG-1:0]           sel;
   logic [NREG-1:0][DW-1:0]   live_regs;
   logic [NREG-1:0][DW-1:0]   shd_words;
   logic                      pgm_go;
   logic [IDX_W-1:0]          lat_idx;
   logic [DW-1:0]             lat_data;

   cfgsh_decode #(.AW(AW), .DEV_TAG(DEV_TAG), .FC_OK(FC_OK)) u_dec (
      .addr    (bus_addr),
      .fc      (bus_fc),
      .rd      (bus_rd),
      .wr      (bus_wr),
      .map_bit (live_regs[IDX_MCR][MAP_BIT]),
      .ack     (bus_ack),
      .sel     (sel)
   );

   cfgsh_regs u_regs (
      .clk       (clk),
      .mrst_n    (mrst_n),
      .wr        (bus_wr),
      .sel       (sel),
      .wdata     (bus_wdata),
      .shd_words (shd_words),
      .live      (live_regs),
      .pgm_go    (pgm_go),
      .lat_idx   (lat_idx),
      .lat_data  (lat_data)
   );

   cfgsh_shadow_store #(.PGM_AND(PGM_AND)) u_store (
      .clk      (clk),
      .por_n    (por_n),
      .erase    (blk_erase),
      .pgm_go   (pgm_go),
      .pgm_idx  (lat_idx),
      .pgm_data (lat_data),
      .words    (shd_words)
   );

   // read mux; unimplemented offsets fall through to zero (R12)
   always_comb begin
      bus_rdata = '0;
      for (int i = 0; i < NREG; i++)
         if (bus_rd && sel[i]) bus_rdata = bus_rdata | live_regs[i];
   end
endmodule

// File: rtl/cfgsh_chk.sv
module cfgsh_chk
   import cfgsh_pkg::*;
(
   input logic                      clk,
   input logic                      por_n,
   input logic                      mrst_n,
   input logic [23:0]               bus_addr,
   input logic [2:0]                bus_fc,
   input logic                      bus_rd,
   input logic                      bus_wr,
   input logic [15:0]               bus_rdata,
   input logic                      bus_ack,
   input logic                      blk_erase,
   input logic                      pgm_go,
   input logic [NREG-1:0][DW-1:0]   shd_words,
   input logic [NREG-1:0][DW-1:0]   live_regs
);
   logic unimpl_off;
   assign unimpl_off = (bus_addr[4:0] != 5'h00) && (bus_addr[4:0] != 5'h04)
                    && (bus_addr[4:0] != 5'h08);

   p_fc_gate_r2: assert property (@(posedge clk) disable iff (!por_n)
      (bus_fc != 3'b101) |-> !bus_ack);

   p_ack_req_r3: assert property (@(posedge clk) disable iff (!por_n)
      !(bus_rd || bus_wr) |-> !bus_ack);

   p_unimpl_zero_r12: assert property (@(posedge clk) disable iff (!por_n)
      (bus_rd && bus_ack && unimpl_off) |-> (bus_rdata == '0));

   p_shadow_hold_r6: assert property (@(posedge clk) disable iff (!por_n)
      (!blk_erase && !pgm_go) |=> $stable(shd_words));

   p_erase_ones_r10: assert property (@(posedge clk) disable iff (!por_n)
      blk_erase |=> (shd_words == '1));

   p_mrst_load_r5: assert property (@(posedge clk) disable iff (!por_n)
      !mrst_n |=> (live_regs[IDX_BAR] == $past(shd_words[IDX_BAR])));
endmodule

bind cfgsh_regblk cfgsh_chk u_chk (
   .clk       (clk),
   .por_n     (por_n),
   .mrst_n    (mrst_n),
   .bus_addr  (bus_addr),
   .bus_fc    (bus_fc),
   .bus_rd    (bus_rd),
   .bus_wr    (bus_wr),
   .bus_rdata (bus_rdata),
   .bus_ack   (bus_ack),
   .blk_erase (blk_erase),
   .pgm_go    (pgm_go),
   .shd_words (shd_words),
   .live_regs (live_regs)
);

// File: tb/sim_cfgsh_regblk.sv
`timescale 1ns/1ps
module sim_cfgsh_regblk;
   localparam logic [17:0] TAG = 18'h2A5C3;

   logic        clk = 1'b0;
   logic        por_n = 1'b0;
   logic        mrst_n = 1'b0;
   logic [23:0] bus_addr = '0;
   logic [2:0]  bus_fc = '0;
   logic        bus_rd = 1'b0;
   logic        bus_wr = 1'b0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic        bus_ack;
   logic        blk_erase = 1'b0;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   cfgsh_regblk u0 (
      .clk(clk), .por_n(por_n), .mrst_n(mrst_n), .bus_addr(bus_addr),
      .bus_fc(bus_fc), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .bus_ack(bus_ack), .blk_erase(blk_erase)
   );

   function automatic logic [23:0] adr(input logic map, input logic [4:0] off);
      return {map, TAG, off};
   endfunction

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic rd(input logic [23:0] a, input logic [2:0] fc,
                     output logic [15:0] d, output logic k);
      @(negedge clk);
      bus_addr = a; bus_fc = fc; bus_rd = 1'b1;
      #2;
      d = bus_rdata; k = bus_ack;
      @(posedge clk); #1;
      bus_rd = 1'b0;
   endtask

   task automatic wr(input logic [23:0] a, input logic [2:0] fc, input logic [15:0] d,
                     output logic k);
      @(negedge clk);
      bus_addr = a; bus_fc = fc; bus_wr = 1'b1; bus_wdata = d;
      #2;
      k = bus_ack;
      @(posedge clk); #1;
      bus_wr = 1'b0;
   endtask

   task automatic mrst();
      @(negedge clk); mrst_n = 1'b0;
      @(negedge clk); mrst_n = 1'b1;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual hung expected done");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [15:0] d;
      logic k;
      repeat (3) @(negedge clk);
      por_n = 1'b1;
      @(negedge clk); mrst_n = 1'b1;

      // reset state from erased shadow row
      rd(adr(1'b1, 5'h00), 3'b101, d, k); chk("R11 MCR", d, 16'h80FF); chk("R3 ack", {15'd0,k}, 16'd1);
      rd(adr(1'b1, 5'h04), 3'b101, d, k); chk("R11 BAR", d, 16'hFFFF);
      rd(adr(1'b1, 5'h08), 3'b101, d, k); chk("R11 HVC", d, 16'h0F00);
      @(negedge clk); #2; chk("R3 idle ack", {15'd0,bus_ack}, 16'd0);

      // function code sweep
      for (int f = 0; f < 8; f++) begin
         rd(adr(1'b1, 5'h00), 3'(f), d, k);
         chk("R2 fc ack", {15'd0,k}, {15'd0, f == 5});
      end
      wr(adr(1'b1, 5'h04), 3'b001, 16'h1111, k);
      rd(adr(1'b1, 5'h04), 3'b101, d, k); chk("R2 bad fc write", d, 16'hFFFF);

      // address decode sweep
      rd(adr(1'b0, 5'h00), 3'b101, d, k); chk("R1 map mismatch", {15'd0,k}, 16'd0);
      for (int b = 5; b < 23; b++) begin
         rd(adr(1'b1, 5'h00) ^ (24'd1 << b), 3'b101, d, k);
         chk("R1 tag bit", {15'd0,k}, 16'd0);
      end

      // offset sweep, reads then writes on unimplemented offsets
      for (int o = 0; o < 32; o++) begin
         logic [15:0] e;
         e = (o == 0) ? 16'h80FF : (o == 4) ? 16'hFFFF : (o == 8) ? 16'h0F00 : 16'h0000;
         rd(adr(1'b1, 5'(o)), 3'b101, d, k);
         chk("R12 R4 offset read", d, e);
         chk("R12 offset ack", {15'd0,k}, 16'd1);
         if (o != 0 && o != 4 && o != 8) begin
            wr(adr(1'b1, 5'(o)), 3'b101, 16'hFFFF, k);
            rd(adr(1'b1, 5'(o)), 3'b101, d, k);
            chk("R12 unimpl write", d, 16'h0000);
         end
      end

      // normal writes and masking
      wr(adr(1'b1, 5'h04), 3'b101, 16'h1234, k);
      rd(adr(1'b1, 5'h04), 3'b101, d, k); chk("R4 BAR write", d, 16'h1234);
      wr(adr(1'b1, 5'h08), 3'b101, 16'hFFFC, k);
      rd(adr(1'b1, 5'h08), 3'b101, d, k); chk("R4 HVC mask", d, 16'h0F00);
      wr(adr(1'b1, 5'h00), 3'b101, 16'h7FFF, k);
      rd(adr(1'b1, 5'h00), 3'b101, d, k); chk("R1 moved away", {15'd0,k}, 16'd0);
      rd(adr(1'b0, 5'h00), 3'b101, d, k); chk("R4 MCR mask", d, 16'h00FF);

      // normal writes left the shadow untouched
      mrst();
      rd(adr(1'b1, 5'h04), 3'b101, d, k); chk("R6 BAR after reset", d, 16'hFFFF);
      rd(adr(1'b1, 5'h00), 3'b101, d, k); chk("R5 MCR after reset", d, 16'h80FF);

      // shadow programming of BAR
      wr(adr(1'b1, 5'h08), 3'b101, 16'h0002, k);
      wr(adr(1'b1, 5'h08), 3'b101, 16'h0F02, k);
      rd(adr(1'b1, 5'h08), 3'b101, d, k); chk("R7 HVC live bits only", d, 16'h0002);
      wr(adr(1'b1, 5'h04), 3'b101, 16'hAAAA, k);
      rd(adr(1'b1, 5'h04), 3'b101, d, k); chk("R7 BAR live kept", d, 16'hFFFF);
      wr(adr(1'b1, 5'h04), 3'b101, 16'h5A5A, k);
      wr(adr(1'b1, 5'h08), 3'b101, 16'h0003, k);
      rd(adr(1'b1, 5'h04), 3'b101, d, k); chk("R9 not yet visible", d, 16'hFFFF);
      rd(adr(1'b1, 5'h08), 3'b101, d, k); chk("R8 hv enable set", d, 16'h0003);
      wr(adr(1'b1, 5'h08), 3'b101, 16'h0000, k);
      mrst();
      rd(adr(1'b1, 5'h04), 3'b101, d, k); chk("R8 R9 BAR programmed", d, 16'h5A5A);
      rd(adr(1'b1, 5'h08), 3'b101, d, k); chk("R5 HVC after reset", d, 16'h0F00);

      // second program pass clears further bits only
      wr(adr(1'b1, 5'h08), 3'b101, 16'h0002, k);
      wr(adr(1'b1, 5'h04), 3'b101, 16'h0FF0, k);
      wr(adr(1'b1, 5'h08), 3'b101, 16'h0003, k);
      wr(adr(1'b1, 5'h08), 3'b101, 16'h0000, k);
      mrst();
      rd(adr(1'b1, 5'h04), 3'b101, d, k); chk("R8 AND program", d, 16'h0A50);

      // erase of the low block
      @(negedge clk); blk_erase = 1'b1;
      @(negedge clk); blk_erase = 1'b0;
      rd(adr(1'b1, 5'h04), 3'b101, d, k); chk("R9 erase not live yet", d, 16'h0A50);
      mrst();
      rd(adr(1'b1, 5'h04), 3'b101, d, k); chk("R10 erased BAR", d, 16'hFFFF);
      rd(adr(1'b1, 5'h00), 3'b101, d, k); chk("R10 erased MCR", d, 16'h80FF);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule